// File: doc/BRIEF.md
# Masked Priority Interrupt Encoder

This block gathers sixteen level-sensitive interrupt lines from peripheral devices and presents one interrupt request to the CPU. Each line is captured every clock into a status register, so a status bit is set while its line is high and clear while it is low. The status is combined with a software-written enable mask to form the pending set. The CPU request is raised whenever that set is non-empty.

On the CPU side, software writes the enable mask and can read it back. It can also read a vector that names the most urgent pending source. Line 0 is the most urgent and line 15 the least. The vector is the winning index plus one, times four, so a vector of zero means nothing is pending. After reset only line 4 is enabled. The request and the vector are both registered outputs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: On every rising clock edge, status bit n takes the level of `irq_lines[n]`. Setting and clearing follow the line with no latching.
- R2: A line whose mask bit is 0 never contributes to `cpu_irq` or `vec_rd_data`, however long it stays asserted.
- R3: `cpu_irq` is 1 exactly when the pending set (status AND mask) held a non-zero value during the previous clock cycle.
- R4: When any line is pending, `vec_rd_data` equals (n+1)*4, where n is the lowest-numbered pending line. Bits [1:0] are always 0. The output registers the pending set from the previous cycle, the same timing as `cpu_irq`.
- R5: When no line is pending, `vec_rd_data` is 0.
- R6: A cycle with `mask_wr_en` high loads `mask_wr_data` into the mask. The new value appears on `mask_rd_data` after that edge, and it governs `cpu_irq` and `vec_rd_data` from the following edge on.
- R7: While `rst` is high, the mask resets to 0x0010 (only line 4 enabled), the status clears to zero, and both `cpu_irq` and `vec_rd_data` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Level-sensitive device interrupt lines |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 16 | New mask value; 1 enables a line |
| mask_rd_data | output | 16 | Current mask value |
| vec_rd_data | output | 7 | Priority vector, (index+1)*4 or 0 |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions assume that `irq_lines`, `mask_wr_en` and `mask_wr_data` are synchronous to `clk` and stable around its rising edge. Lines coming from another clock domain must be synchronised before they reach this block. The bench changes all inputs on the falling edge, so every value is settled half a period before it is sampled. It covers single lines, many lines at once, lines blocked by the mask, and mask writes made while lines are held. It then runs a long stretch of pseudo-random line and mask activity.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned LINES_DEF     = 16;
  localparam int unsigned VEC_SHIFT_DEF = 2;

  function automatic int unsigned vec_width(input int unsigned lines, input int unsigned shift);
    return $clog2(lines + 1) + shift;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_in,
  output logic [NUM_LINES-1:0] status_q
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else     status_q[g] <= lines_in[g];
    end
  end

  assert_status_follow_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q == $past(lines_in)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned           NUM_LINES  = 16,
  parameter logic [NUM_LINES-1:0]  MASK_RESET = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)        mask_q <= MASK_RESET;
    else if (wr_en) mask_q <= wr_data;
  end

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mask_q == $past(wr_data)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned VEC_SHIFT = 2,
  parameter int unsigned VEC_W     = 7
) (
  input  logic [NUM_LINES-1:0] pend,
  output logic [VEC_W-1:0]     vec,
  output logic                 any
);
  always_comb begin
    vec = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend[i]) vec = VEC_W'((i + 1) << VEC_SHIFT);
    end
    any = |pend;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned          NUM_LINES  = LINES_DEF,
  parameter int unsigned          VEC_SHIFT  = VEC_SHIFT_DEF,
  parameter logic [NUM_LINES-1:0] MASK_RESET = 16'h0010,
  localparam int unsigned         VEC_W      = vec_width(NUM_LINES, VEC_SHIFT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 mask_wr_en,
  input  logic [NUM_LINES-1:0] mask_wr_data,
  output logic [NUM_LINES-1:0] mask_rd_data,
  output logic [VEC_W-1:0]     vec_rd_data,
  output logic                 cpu_irq
);
  logic [NUM_LINES-1:0] status;
  logic [NUM_LINES-1:0] mask;
  logic [NUM_LINES-1:0] pending;
  logic [VEC_W-1:0]     vec_next;
  logic                 any_next;

  irq_status_reg #(.NUM_LINES(NUM_LINES)) status_i (
    .clk(clk), .rst(rst), .lines_in(irq_lines), .status_q(status));

  irq_mask_reg #(.NUM_LINES(NUM_LINES), .MASK_RESET(MASK_RESET)) mask_i (
    .clk(clk), .rst(rst), .wr_en(mask_wr_en), .wr_data(mask_wr_data), .mask_q(mask));

  assign pending = status & mask;

  irq_prio_enc #(.NUM_LINES(NUM_LINES), .VEC_SHIFT(VEC_SHIFT), .VEC_W(VEC_W)) enc_i (
    .pend(pending), .vec(vec_next), .any(any_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq     <= 1'b0;
      vec_rd_data <= '0;
    end else begin
      cpu_irq     <= any_next;
      vec_rd_data <= vec_next;
    end
  end

  assign mask_rd_data = mask;

  assert_irq_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == ($past(status & mask) != '0)));

  assert_vec_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !cpu_irq |-> (vec_rd_data == '0));

  assert_vec_form_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> ((vec_rd_data != '0) && (vec_rd_data[1:0] == 2'b00)));

  assert_masked_silent_R2: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> !cpu_irq);
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_lines = '0;
  logic        mask_wr_en = 1'b0;
  logic [15:0] mask_wr_data = '0;
  logic [15:0] mask_rd_data;
  logic [6:0]  vec_rd_data;
  logic        cpu_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R7";

  // reference model state
  logic [15:0] m_status, m_mask;
  int          m_vec;
  logic        m_irq;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .mask_rd_data(mask_rd_data),
    .vec_rd_data(vec_rd_data), .cpu_irq(cpu_irq));

  always @(posedge clk) begin
    logic [15:0] pend;
    int v;
    pend = m_status & m_mask;
    v = 0;
    for (int i = 0; i < 16; i++) if (pend[i] && v == 0) v = (i + 1) * 4;
    if (rst) begin
      m_status = '0; m_mask = 16'h0010; m_irq = 0; m_vec = 0;
    end else begin
      m_irq = (pend != 0);
      m_vec = v;
      m_status = irq_lines;
      if (mask_wr_en) m_mask = mask_wr_data;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check({phase, " irq (R3)"}, int'(cpu_irq), int'(m_irq));
    check((m_vec == 0) ? {phase, " vec R5"} : {phase, " vec R4"}, int'(vec_rd_data), m_vec);
    check({phase, " mask R6"}, int'(mask_rd_data), int'(m_mask));
  endtask

  task automatic cyc(input logic [15:0] l, input logic we, input logic [15:0] d);
    @(negedge clk);
    compare();
    irq_lines = l; mask_wr_en = we; mask_wr_data = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state, lines asserted during reset must not show
    irq_lines = 16'hffff;
    @(negedge clk);
    check("R7 mask", int'(mask_rd_data), 16'h0010);
    check("R7 irq", int'(cpu_irq), 0);
    check("R7 vec", int'(vec_rd_data), 0);
    irq_lines = '0;
    @(negedge clk);
    rst = 1'b0;
    // only line 4 enabled after reset
    phase = "R2";
    cyc(16'h0001, 0, 0); cyc(16'h0001, 0, 0); cyc(16'h0010, 0, 0);
    cyc(16'h0010, 0, 0); cyc(16'h0000, 0, 0); cyc(16'h0000, 0, 0);
    // R1 walk each line with all enabled
    phase = "R1";
    cyc(16'h0000, 1, 16'hffff);
    for (int i = 0; i < 16; i++) begin
      cyc(16'(1 << i), 0, 0); cyc(16'(1 << i), 0, 0); cyc(16'h0000, 0, 0);
    end
    // R4 multiple lines: lowest wins
    phase = "R4";
    cyc(16'h8000, 0, 0); cyc(16'hc000, 0, 0); cyc(16'hfff0, 0, 0);
    cyc(16'hffff, 0, 0); cyc(16'h8421, 0, 0); cyc(16'h8420, 0, 0);
    cyc(16'h0000, 0, 0); cyc(16'h0000, 0, 0);
    // R2 masked lines ignored, unmasked highest index still wins
    phase = "R2";
    cyc(16'hffff, 1, 16'h8000); cyc(16'hffff, 0, 0); cyc(16'h7fff, 0, 0);
    cyc(16'h7fff, 0, 0); cyc(16'hffff, 1, 16'h0000); cyc(16'hffff, 0, 0);
    cyc(16'hffff, 0, 0);
    // R6 mask changes while lines held
    phase = "R6";
    cyc(16'h0f0f, 1, 16'h0100); cyc(16'h0f0f, 1, 16'h0002); cyc(16'h0f0f, 1, 16'h0808);
    cyc(16'h0f0f, 0, 0); cyc(16'h0f0f, 1, 16'h00f0); cyc(16'h0f0f, 0, 0);
    // R5 nothing pending
    phase = "R5";
    cyc(16'h0000, 1, 16'hffff); cyc(16'h0000, 0, 0); cyc(16'h0000, 0, 0);
    // pseudo-random mix
    phase = "mix";
    for (int i = 0; i < 400; i++)
      cyc(16'($urandom), ($urandom % 4) == 0, 16'($urandom));
    cyc(16'h0000, 0, 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule